// File: doc/BRIEF.md
# Port I/O Contention Check Sequencer

This block runs beside a CPU core that emulates a home computer with shared video memory. When the core starts a port input or output cycle, it pulses a start strobe. The block then captures the port address and the machine variant and steps through the four T-states of the I/O cycle. In each T-state it reports whether the contention logic must look up a delay for that T-state. The answer depends on three things: whether the upper two address bits select the video-shared quarter of the address space, the value of address bit 0, and the machine variant. Late variants tie contention only to memory requests, so port cycles on them never request a check.

Alongside the flag, the block gives a lookup index into an external delay table. The index is the current frame T-state plus a per-variant offset, folded back once into the frame when the sum reaches the frame length. The frame length is an input, so one instance can serve frames of different lengths. The delay table and the clock stretching that uses it live outside this block.

Top module: `io_contention_seq`

## Requirements
- R1: An accepted start strobe makes `busy` high for the next four clocks, with `io_tcycle` reading 1, 2, 3 and 4 in turn. After that `busy` goes low and `io_tcycle` reads 0, unless a new cycle is chained.
- R2: On machine codes 0 (48K class) and 1 (128K class), an address with bits [15:14] = 2'b01 and bit 0 = 1 raises `chk_en` in all four T-states.
- R3: On codes 0 and 1, an address with bits [15:14] = 2'b01 and bit 0 = 0 raises `chk_en` in T-states 1 and 2 only.
- R4: On codes 0 and 1, an address with bits [15:14] other than 2'b01 and bit 0 = 1 never raises `chk_en`.
- R5: On codes 0 and 1, an address with bits [15:14] other than 2'b01 and bit 0 = 0 raises `chk_en` in T-state 2 only.
- R6: Machine codes 2 and 3 (late variants) never raise `chk_en` during a port cycle, whatever the address.
- R7: `lookup_idx` equals `cur_tstate` plus an offset chosen by the latched machine code: 5 for code 0 and 7 for codes 1 to 3. When the sum is equal to or greater than `frame_len`, `frame_len` is subtracted once.
- R8: The address and machine code are captured only when a start is accepted. Changing them during a cycle does not alter that cycle's flags or index offset.
- R9: A start strobe during T-states 1 to 3 is ignored. A start during T-state 4 is accepted and makes the next clock T-state 1 of a new cycle.
- R10: After reset, `busy` is 0, `io_tcycle` is 0 and `chk_en` is 0, and the latched machine code is 0. `chk_en` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | Start of a port I/O cycle |
| port_addr | input | ADDR_W | Port address of the I/O cycle |
| mach_sel | input | 2 | Machine code: 0 = 48K class, 1 = 128K class, 2/3 = late variants |
| cur_tstate | input | TS_W | Current T-state within the frame |
| frame_len | input | TS_W | Frame length in T-states |
| busy | output | 1 | A port cycle is in progress |
| io_tcycle | output | 3 | T-state number 1 to 4, or 0 when idle |
| chk_en | output | 1 | Contention lookup applies in this T-state |
| lookup_idx | output | TS_W | Offset and wrapped T-state for the delay table |

## Verification
The bench covers the address range edges 0x3FFF, 0x4000, 0x7FFF and 0x8000, with both values of bit 0 and all four machine codes. A design with a wrong range decode would flag the wrong neighbour, and one that swaps the two bit-0 patterns would flag T-state 1 where only T-state 2 is allowed. The bench changes the address and machine code in the middle of each cycle. It also pulses the start strobe in T-state 2 and chains a new cycle from T-state 4. A design that relatches, restarts or fails to chain would then show a wrong flag or a wrong T-state number. The lookup index is probed at T-states just below, at and above the fold point. An off-by-one in the compare, or using the wrong offset for a machine code, would return an index that is out of the frame or shifted.

// File: rtl/io_cont_pkg.sv
package io_cont_pkg;

   localparam int N_PH = 4;
   localparam int PH_W = $clog2(N_PH + 1);

   typedef enum logic [1:0] {
      MACH_48K      = 2'b00,
      MACH_128K     = 2'b01,
      MACH_LATE     = 2'b10,
      MACH_LATE_ALT = 2'b11
   } mach_e;

   function automatic logic port_quiet(mach_e m);
      return (m == MACH_LATE) || (m == MACH_LATE_ALT);
   endfunction

   // bit g set means T-state g+1 carries a check
   function automatic logic [N_PH-1:0] phase_mask(logic in_range, logic low_bit);
      logic [N_PH-1:0] m;
      case ({in_range, low_bit})
         2'b11:   m = 4'b1111;
         2'b10:   m = 4'b0011;
         2'b00:   m = 4'b0010;
         default: m = 4'b0000;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/io_cont_phase.sv
module io_cont_phase
   import io_cont_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output logic            accept,
   output logic            active,
   output logic [PH_W-1:0] phase
);

   localparam logic [PH_W-1:0] LAST = PH_W'(N_PH);

   assign accept = start && ((phase == '0) || (phase == LAST));
   assign active = (phase != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= '0;
      end else if (accept) begin
         phase <= PH_W'(1);
      end else if (phase == LAST) begin
         phase <= '0;
      end else if (phase != '0) begin
         phase <= phase + PH_W'(1);
      end
   end

endmodule

// File: rtl/io_cont_pattern.sv
module io_cont_pattern
   import io_cont_pkg::*;
(
   input  logic            active,
   input  logic            in_range,
   input  logic            low_bit,
   input  logic            quiet,
   input  logic [PH_W-1:0] phase,
   output logic            chk
);

   logic [N_PH-1:0] mask;
   logic [N_PH-1:0] sel;

   assign mask = quiet ? '0 : phase_mask(in_range, low_bit);

   for (genvar g = 0; g < N_PH; g++) begin : g_ph
      assign sel[g] = (phase == PH_W'(g + 1));
   end

   assign chk = active && |(mask & sel);

endmodule

// File: rtl/io_cont_idx.sv
module io_cont_idx
   import io_cont_pkg::*;
#(
   parameter int TS_W     = 17,
   parameter int OFS_48   = 5,
   parameter int OFS_128  = 7,
   parameter int OFS_LATE = 7,
   parameter bit IDX_REG  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  mach_e           mach,
   input  logic [TS_W-1:0] tstate,
   input  logic [TS_W-1:0] frame_len,
   output logic [TS_W-1:0] idx
);

   localparam int SUM_W = TS_W + 1;

   if (OFS_48 >= (1 << TS_W) || OFS_128 >= (1 << TS_W) || OFS_LATE >= (1 << TS_W)) begin : g_bad_ofs
      $error("io_cont_idx: offset does not fit TS_W");
   end

   logic [SUM_W-1:0] ofs;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] flen_x;
   logic [TS_W-1:0]  folded;

   always_comb begin
      case (mach)
         MACH_48K:  ofs = SUM_W'(OFS_48);
         MACH_128K: ofs = SUM_W'(OFS_128);
         default:   ofs = SUM_W'(OFS_LATE);
      endcase
   end

   assign flen_x = {1'b0, frame_len};
   assign sum    = {1'b0, tstate} + ofs;

   always_comb begin
      logic [SUM_W-1:0] t;
      t      = (sum >= flen_x) ? (sum - flen_x) : sum;
      folded = t[TS_W-1:0];
   end

   if (IDX_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) idx <= '0;
         else        idx <= folded;
      end
   end else begin : g_comb
      assign idx = folded;
   end

endmodule

// File: rtl/io_contention_seq.sv
module io_contention_seq
   import io_cont_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int TS_W     = 17,
   parameter int OFS_48   = 5,
   parameter int OFS_128  = 7,
   parameter int OFS_LATE = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_start,
   input  logic [ADDR_W-1:0] port_addr,
   input  logic [1:0]        mach_sel,
   input  logic [TS_W-1:0]   cur_tstate,
   input  logic [TS_W-1:0]   frame_len,
   output logic              busy,
   output logic [PH_W-1:0]   io_tcycle,
   output logic              chk_en,
   output logic [TS_W-1:0]   lookup_idx
);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("io_contention_seq: ADDR_W must be at least 2");
   end
   if (TS_W < 4) begin : g_bad_ts
      $error("io_contention_seq: TS_W must be at least 4");
   end

   localparam logic [1:0] RANGE_TAG = 2'b01;

   logic  start_ok;
   logic  range_q;
   logic  bit0_q;
   mach_e mach_q;

   io_cont_phase u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (cyc_start),
      .accept (start_ok),
      .active (busy),
      .phase  (io_tcycle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         range_q <= 1'b0;
         bit0_q  <= 1'b0;
         mach_q  <= MACH_48K;
      end else if (start_ok) begin
         range_q <= (port_addr[ADDR_W-1 -: 2] == RANGE_TAG);
         bit0_q  <= port_addr[0];
         mach_q  <= mach_e'(mach_sel);
      end
   end

   io_cont_pattern u_pattern (
      .active   (busy),
      .in_range (range_q),
      .low_bit  (bit0_q),
      .quiet    (port_quiet(mach_q)),
      .phase    (io_tcycle),
      .chk      (chk_en)
   );

   io_cont_idx #(
      .TS_W     (TS_W),
      .OFS_48   (OFS_48),
      .OFS_128  (OFS_128),
      .OFS_LATE (OFS_LATE),
      .IDX_REG  (1'b0)
   ) u_idx (
      .clk       (clk),
      .rst_n     (rst_n),
      .mach      (mach_q),
      .tstate    (cur_tstate),
      .frame_len (frame_len),
      .idx       (lookup_idx)
   );

endmodule

// File: rtl/io_contention_seq_chk.sv
module io_contention_seq_chk #(
   parameter int TS_W = 17
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cyc_start,
   input logic            busy,
   input logic [2:0]      io_tcycle,
   input logic            chk_en,
   input logic            range_q,
   input logic            bit0_q,
   input logic [1:0]      mach_q,
   input logic [TS_W-1:0] cur_tstate,
   input logic [TS_W-1:0] frame_len,
   input logic [TS_W-1:0] lookup_idx
);

   // R1 and R9: T-states 1..3 always advance, a start there changes nothing
   a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && io_tcycle != 3'd4) |=> (io_tcycle == 3'($past(io_tcycle) + 3'd1)));

   a_r1_end: assert property (@(posedge clk) disable iff (!rst_n)
      (io_tcycle == 3'd4 && !cyc_start) |=> !busy);

   a_r9_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (io_tcycle == 3'd4 && cyc_start) |=> (io_tcycle == 3'd1));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !chk_en);

   a_r4_no_check: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !range_q && bit0_q) |-> !chk_en);

   a_r6_late_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mach_q[1]) |-> !chk_en);

   a_r5_t2_checked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && io_tcycle == 3'd2 && !bit0_q && !mach_q[1]) |-> chk_en);

   a_r7_idx_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_tstate < frame_len && frame_len > TS_W'(7)) |-> (lookup_idx < frame_len));

endmodule

bind io_contention_seq io_contention_seq_chk #(.TS_W(TS_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_start  (cyc_start),
   .busy       (busy),
   .io_tcycle  (io_tcycle),
   .chk_en     (chk_en),
   .range_q    (range_q),
   .bit0_q     (bit0_q),
   .mach_q     (mach_q),
   .cur_tstate (cur_tstate),
   .frame_len  (frame_len),
   .lookup_idx (lookup_idx)
);

// File: tb/test_io_contention_seq.sv
`timescale 1ns/1ps
module test_io_contention_seq;

   localparam int TS_W = 17;
   localparam int FL48 = 69888;
   localparam int FL128 = 70908;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cyc_start;
   logic [15:0]     port_addr;
   logic [1:0]      mach_sel;
   logic [TS_W-1:0] cur_ts;
   logic [TS_W-1:0] frame_len;
   logic            busy;
   logic [2:0]      io_tcycle;
   logic            chk_en;
   logic [TS_W-1:0] lookup_idx;

   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   io_contention_seq #(.TS_W(TS_W)) i_io_contention_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_start  (cyc_start),
      .port_addr  (port_addr),
      .mach_sel   (mach_sel),
      .cur_tstate (cur_ts),
      .frame_len  (frame_len),
      .busy       (busy),
      .io_tcycle  (io_tcycle),
      .chk_en     (chk_en),
      .lookup_idx (lookup_idx)
   );

   function automatic logic [3:0] exp_mask(logic [15:0] a, logic [1:0] m);
      if (m[1]) return 4'b0000;
      if (a[15:14] == 2'b01) return a[0] ? 4'b1111 : 4'b0011;
      return a[0] ? 4'b0000 : 4'b0010;
   endfunction

   function automatic string req_of(logic [15:0] a, logic [1:0] m);
      if (m[1]) return "R6";
      if (a[15:14] == 2'b01) return a[0] ? "R2" : "R3";
      return a[0] ? "R4" : "R5";
   endfunction

   function automatic int exp_idx(int ts, logic [1:0] m, int fl);
      int s;
      s = ts + ((m == 2'd0) ? 5 : 7);
      if (s >= fl) s = s - fl;
      return s;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic run_io(input logic [15:0] a, input logic [1:0] m, input bit noise,
                         input bit chain_in, input bit chain_out,
                         input logic [15:0] na, input logic [1:0] nm);
      logic [3:0] mk;
      string rq;
      mk = exp_mask(a, m);
      rq = req_of(a, m);
      if (!chain_in) begin
         @(negedge clk);
         cyc_start = 1'b1; port_addr = a; mach_sel = m;
      end
      for (int t = 1; t <= 4; t++) begin
         @(negedge clk);
         cyc_start = 1'b0;
         port_addr = 16'($urandom);   // R8: ignored mid-cycle
         mach_sel  = 2'($urandom);
         cur_ts    = TS_W'($urandom % frame_len);
         if (t == 2) cur_ts = frame_len - TS_W'(1);
         if (t == 3) cur_ts = frame_len - TS_W'(8);
         if (noise && t == 2) cyc_start = 1'b1;   // R9: ignored start
         if (chain_out && t == 4) begin
            cyc_start = 1'b1; port_addr = na; mach_sel = nm;
         end
         #1;
         check(busy == 1'b1, "R1 busy", int'(busy), 1);
         check(io_tcycle == 3'(t), "R1/R9 tcycle", int'(io_tcycle), t);
         check(chk_en == mk[t-1], rq, int'(chk_en), int'(mk[t-1]));
         check(int'(lookup_idx) == exp_idx(int'(cur_ts), m, int'(frame_len)),
               "R7/R8 idx", int'(lookup_idx), exp_idx(int'(cur_ts), m, int'(frame_len)));
      end
      if (!chain_out) begin
         @(negedge clk);
         cyc_start = 1'b0;
         #1;
         check(busy == 1'b0, "R1 idle", int'(busy), 0);
         check(io_tcycle == 3'd0, "R1 idle tcycle", int'(io_tcycle), 0);
         check(chk_en == 1'b0, "R10 idle chk", int'(chk_en), 0);
      end
   endtask

   task automatic probe_idx(input int ts, input logic [1:0] m);
      @(negedge clk);
      cur_ts = TS_W'(ts);
      #1;
      check(int'(lookup_idx) == exp_idx(ts, m, int'(frame_len)), "R7 fold",
            int'(lookup_idx), exp_idx(ts, m, int'(frame_len)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] addrs [8];
      void'($urandom(32'd20240611));
      addrs = '{16'h3FFF, 16'h3FFE, 16'h4000, 16'h4001,
                16'h7FFF, 16'h7FFE, 16'h8000, 16'h8001};
      rst_n = 1'b0; cyc_start = 1'b0; port_addr = '0; mach_sel = '0;
      frame_len = TS_W'(FL48); cur_ts = TS_W'(FL48 - 2);
      repeat (3) @(negedge clk);
      #1;
      check(busy == 1'b0, "R10 reset busy", int'(busy), 0);
      check(io_tcycle == 3'd0, "R10 reset tcycle", int'(io_tcycle), 0);
      check(chk_en == 1'b0, "R10 reset chk", int'(chk_en), 0);
      check(int'(lookup_idx) == 3, "R10/R7 reset idx", int'(lookup_idx), 3);
      @(negedge clk);
      rst_n = 1'b1;

      for (int m = 0; m < 4; m++)
         for (int k = 0; k < 8; k++)
            run_io(addrs[k], 2'(m), 1'b0, 1'b0, 1'b0, 16'h0, 2'd0);

      run_io(16'h4000, 2'd1, 1'b1, 1'b0, 1'b0, 16'h0, 2'd0);
      run_io(16'hC001, 2'd0, 1'b1, 1'b0, 1'b0, 16'h0, 2'd0);
      run_io(16'h8001, 2'd0, 1'b0, 1'b0, 1'b1, 16'h4001, 2'd1);
      run_io(16'h4001, 2'd1, 1'b0, 1'b1, 1'b1, 16'h00FE, 2'd2);
      run_io(16'h00FE, 2'd2, 1'b0, 1'b1, 1'b0, 16'h0, 2'd0);

      frame_len = TS_W'(FL128);
      run_io(16'h5555, 2'd1, 1'b0, 1'b0, 1'b0, 16'h0, 2'd0);
      probe_idx(FL128 - 1, 2'd1);
      probe_idx(FL128 - 7, 2'd1);
      probe_idx(FL128 - 8, 2'd1);
      probe_idx(0, 2'd1);
      frame_len = TS_W'(FL48);
      run_io(16'hFFFE, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0, 2'd0);
      probe_idx(FL48 - 5, 2'd0);
      probe_idx(FL48 - 6, 2'd0);

      for (int i = 0; i < 300; i++) begin
         logic [15:0] a;
         logic [1:0]  m;
         a = 16'($urandom);
         m = 2'($urandom);
         frame_len = (i % 2 == 0) ? TS_W'(FL48) : TS_W'(FL128);
         run_io(a, m, 1'($urandom), 1'b0, 1'b0, 16'h0, 2'd0);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule